// File: doc/BRIEF.md
# ATM Transmit Cell Synchronizer

This block sits between a transmit cell FIFO and a physical-layer framer. It reads 53-octet ATM cells one octet at a time from the FIFO's read port. It hands them to the framer as a byte stream and marks the first octet of every cell with a start-of-cell flag. A cell is opened only when the FIFO reports at least one complete cell. Once opened, the cell runs to its end, so the framer never sees a partial cell. When no complete cell is waiting at a cell boundary, the block raises a no-cell flag so the framer can fill the slot by its own means.

The FIFO read side is first-word-fall-through. The octet at the head of the FIFO is present on `fifo_data`, and a high `fifo_rd` at a clock edge consumes it. `fifo_cells` counts the complete cells whose first octet has not yet been read. The FIFO lowers it by one at the edge where the first octet of a cell is read. The framer side is a valid/ready pair backed by a single output register. An octet is handed over on every edge where both `tx_valid` and `tx_ready` are high.

Top module: `atm_tx_cell_sync`

## Requirements
- R1: Every cell presented to the framer is exactly 53 octets long. Counting octets accepted since reset (an octet is accepted on an edge with `tx_valid` and `tx_ready` high), `tx_soc` is high on accepted octet numbers 0, 53, 106, and so on, and low on all others.
- R2: `tx_soc` is high only while `tx_valid` is high, and only on the first octet of a cell.
- R3: A new cell is started only at a cell boundary and only when `fifo_cells` is non-zero. Octets of an incomplete cell left in the FIFO are never read.
- R4: `tx_nocell` is high exactly when the block is at a cell boundary and `fifo_cells` is zero. While it is high, `fifo_rd` stays low.
- R5: With `tx_ready` held high and complete cells waiting, `tx_valid` stays high on every cycle, including across cell boundaries. The first octet of a cell appears one cycle after the cycle in which it is read.
- R6: Once the first octet of a cell has been read, the remaining 52 octets are read and delivered whatever `fifo_cells` does in the meantime.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_octet`, `tx_soc` and `tx_valid` keep their values on the next cycle.
- R8: Octets reach the framer in FIFO order, without loss or repetition. `fifo_rd` is high only when the output register is empty or is being accepted in the same cycle.
- R9: A synchronous reset (`rst_n` low at a clock edge) empties the output register and returns the block to a cell boundary. The next octet delivered after reset carries `tx_soc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_data | input | OCTET_W | Octet at the head of the transmit cell FIFO |
| fifo_cells | input | CNT_W | Number of complete cells not yet begun |
| fifo_rd | output | 1 | Consume the head octet at this edge |
| tx_octet | output | OCTET_W | Octet to the framer |
| tx_valid | output | 1 | `tx_octet` holds a cell octet |
| tx_soc | output | 1 | Current octet is the first of a cell |
| tx_ready | input | 1 | Framer takes the current octet at this edge |
| tx_nocell | output | 1 | At a cell boundary with no complete cell waiting |

## Verification
At a cell boundary, the framer takes the last octet of one cell in the same cycle as the block reads the first octet of the next cell. Two decisions meet in that edge: the output register frees itself, and the availability test on `fifo_cells` is made. This is provoked by queuing several cells and holding `tx_ready` high. It is judged by the absence of any gap in `tx_valid` across the boundary and by the start-of-cell flag landing on the octet right after the 53rd. The same edge is revisited under alternating, pseudo-random and burst back-pressure, where the frees and the boundary tests fall in different relative cycles.

// File: rtl/atm_txsync_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the transmit cell synchronizer.
// Assumes: one octet per FIFO entry, fixed-length cells.
package atm_txsync_pkg;
    localparam int CELL_OCTETS  = 53;
    localparam int OCTET_BITS   = 8;
    localparam int CELLCNT_BITS = 8;

    // Decision taken at the FIFO side on one cycle
    typedef enum logic [1:0] {
        FETCH_NONE  = 2'd0,
        FETCH_START = 2'd1,
        FETCH_BODY  = 2'd2
    } fetch_kind_t;
endpackage

// File: rtl/atm_txsync_idx.sv
`timescale 1ns/1ps
// Octet position counter inside the current cell.
// Counts 0 .. CELL_LEN-1 and wraps; position 0 means "at a cell boundary".
// Assumes: step is high only when an octet of the cell is read.
module atm_txsync_idx #(
    parameter int CELL_LEN = 53,
    localparam int IDX_W   = $clog2(CELL_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             at_head
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_LEN - 1);

    logic at_tail;

    // Boundary and last-octet decode of the position
    always_comb begin
        at_head = (idx == '0);
        at_tail = (idx == LAST);
    end

    // Advance the position by one octet per read, wrapping after the last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (step) begin
            idx <= at_tail ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/atm_txsync_gate.sv
`timescale 1ns/1ps
// Read decision for the FIFO side.
// Opens a cell only at a boundary with a complete cell waiting; inside a
// cell it keeps reading whenever the output slot can take an octet.
// Assumes: cell_cnt counts complete cells not yet begun.
module atm_txsync_gate #(
    parameter int CNT_W = 8
) (
    input  logic                            at_head,
    input  logic [CNT_W-1:0]                cell_cnt,
    input  logic                            slot_free,
    output atm_txsync_pkg::fetch_kind_t     kind,
    output logic                            fetch,
    output logic                            nocell
);
    import atm_txsync_pkg::*;

    logic cell_waiting;

    // Classify this cycle: start a cell, continue one, or do nothing
    always_comb begin
        cell_waiting = (cell_cnt != '0);
        kind         = FETCH_NONE;
        if (slot_free) begin
            if (!at_head)          kind = FETCH_BODY;
            else if (cell_waiting) kind = FETCH_START;
        end
        fetch  = (kind != FETCH_NONE);
        nocell = at_head && !cell_waiting;
    end
endmodule

// File: rtl/atm_txsync_stage.sv
`timescale 1ns/1ps
// One-entry output register toward the framer.
// Holds octet and start flag while the framer stalls; frees itself when
// the octet is taken and nothing new is loaded.
// Assumes: load is only raised while slot_free is high.
module atm_txsync_stage #(
    parameter int OCTET_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [OCTET_W-1:0] in_octet,
    input  logic               in_first,
    input  logic               take,
    output logic               slot_free,
    output logic [OCTET_W-1:0] out_octet,
    output logic               out_first,
    output logic               out_valid
);
    // Slot can be refilled when empty or emptied on this edge
    always_comb begin
        slot_free = !out_valid || take;
    end

    // Load a new octet, drop a taken one, or hold under back-pressure
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_first <= 1'b0;
            out_octet <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_first <= in_first;
            out_octet <= in_octet;
        end else if (take && out_valid) begin
            out_valid <= 1'b0;
            out_first <= 1'b0;
        end
    end
endmodule

// File: rtl/atm_tx_cell_sync.sv
`timescale 1ns/1ps
// Transmit cell synchronizer: moves whole cells from a first-word-fall-
// through FIFO to a framer, flagging the first octet of each cell.
// Assumes: the FIFO lowers fifo_cells at the edge that reads a cell's
// first octet, and all octets of a counted cell are already stored.
module atm_tx_cell_sync #(
    parameter int OCTET_W  = atm_txsync_pkg::OCTET_BITS,
    parameter int CELL_LEN = atm_txsync_pkg::CELL_OCTETS,
    parameter int CNT_W    = atm_txsync_pkg::CELLCNT_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OCTET_W-1:0] fifo_data,
    input  logic [CNT_W-1:0]   fifo_cells,
    output logic               fifo_rd,
    output logic [OCTET_W-1:0] tx_octet,
    output logic               tx_valid,
    output logic               tx_soc,
    input  logic               tx_ready,
    output logic               tx_nocell
);
    import atm_txsync_pkg::*;

    localparam int IDX_W = $clog2(CELL_LEN);

    logic             at_head;
    logic [IDX_W-1:0] pos;
    logic             slot_free;
    logic             fetch;
    fetch_kind_t      kind;
    logic             first_oct;

    atm_txsync_idx #(.CELL_LEN(CELL_LEN)) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (fetch),
        .idx     (pos),
        .at_head (at_head)
    );

    atm_txsync_gate #(.CNT_W(CNT_W)) u_gate (
        .at_head   (at_head),
        .cell_cnt  (fifo_cells),
        .slot_free (slot_free),
        .kind      (kind),
        .fetch     (fetch),
        .nocell    (tx_nocell)
    );

    // First octet of a cell is the one read as a cell start
    always_comb begin
        first_oct = (kind == FETCH_START) && (pos == '0);
        fifo_rd   = fetch;
    end

    atm_txsync_stage #(.OCTET_W(OCTET_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (fetch),
        .in_octet  (fifo_data),
        .in_first  (first_oct),
        .take      (tx_ready),
        .slot_free (slot_free),
        .out_octet (tx_octet),
        .out_first (tx_soc),
        .out_valid (tx_valid)
    );
endmodule

// File: rtl/atm_tx_cell_sync_chk.sv
`timescale 1ns/1ps
// Property checker for the transmit cell synchronizer, bound to the top.
// Keeps its own octet counters on both sides to judge cell framing.
module atm_tx_cell_sync_chk #(
    parameter int OCTET_W  = 8,
    parameter int CELL_LEN = 53,
    parameter int CNT_W    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CNT_W-1:0]   fifo_cells,
    input logic               fifo_rd,
    input logic [OCTET_W-1:0] tx_octet,
    input logic               tx_valid,
    input logic               tx_soc,
    input logic               tx_ready,
    input logic               tx_nocell
);
    localparam int IDX_W = $clog2(CELL_LEN);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_LEN - 1);

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] out_idx;

    // Independent counts of octets read and octets accepted, per cell
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx  <= '0;
            out_idx <= '0;
        end else begin
            if (fifo_rd)             rd_idx  <= (rd_idx == LAST) ? '0 : rd_idx + 1'b1;
            if (tx_valid && tx_ready) out_idx <= (out_idx == LAST) ? '0 : out_idx + 1'b1;
        end
    end

    assert_soc_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_soc |-> tx_valid);

    assert_soc_position_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_soc == (out_idx == '0)));

    assert_start_needs_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && rd_idx == '0) |-> (fifo_cells != '0));

    assert_nocell_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_nocell |-> !fifo_rd);

    assert_nocell_only_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx != '0) |-> !tx_nocell);

    assert_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cells != '0 && tx_valid && tx_ready) |=> tx_valid);

    assert_cell_completes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx != '0 && (!tx_valid || tx_ready)) |-> fifo_rd);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_octet) && $stable(tx_soc)));

    assert_read_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (!tx_valid || tx_ready));
endmodule

bind atm_tx_cell_sync atm_tx_cell_sync_chk #(
    .OCTET_W  (OCTET_W),
    .CELL_LEN (CELL_LEN),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_cells (fifo_cells),
    .fifo_rd    (fifo_rd),
    .tx_octet   (tx_octet),
    .tx_valid   (tx_valid),
    .tx_soc     (tx_soc),
    .tx_ready   (tx_ready),
    .tx_nocell  (tx_nocell)
);

// File: tb/atm_tx_cell_sync_test.sv
`timescale 1ns/1ps
module atm_tx_cell_sync_test;
    localparam int CL = 53;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fifo_data = 8'h00;
    logic [7:0] fifo_cells = 8'h00;
    logic       fifo_rd;
    logic [7:0] tx_octet;
    logic       tx_valid;
    logic       tx_soc;
    logic       tx_ready = 1'b0;
    logic       tx_nocell;

    always #2 clk = ~clk;

    atm_tx_cell_sync uut (
        .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data), .fifo_cells(fifo_cells),
        .fifo_rd(fifo_rd), .tx_octet(tx_octet), .tx_valid(tx_valid),
        .tx_soc(tx_soc), .tx_ready(tx_ready), .tx_nocell(tx_nocell)
    );

    // Scenario table: {cells[7:0], ready pattern[3:0]}
    // pattern 0 always ready, 1 alternate, 2 pseudo-random, 3 bursts
    localparam logic [11:0] VEC [0:5] = '{12'h010, 12'h030, 12'h021,
                                          12'h042, 12'h023, 12'h052};

    int checks = 0;
    int errors = 0;
    logic [7:0] q[$];
    logic [7:0] expq[$];
    int pending = 0;
    int rd_pos = 0;
    int out_pos = 0;
    bit pop_pend = 0;
    logic [7:0] seq = 8'h11;
    logic [15:0] lfsr = 16'hACE1;
    int cyc = 0;
    int accepted = 0;
    int socs = 0;
    int reads = 0;
    int first_acc = -1;
    int last_acc = -1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit ready_of(input int mode);
        case (mode)
            0: return 1'b1;
            1: return cyc[0];
            2: return lfsr[0] | lfsr[3];
            default: return (cyc % 7) < 4;
        endcase
    endfunction

    task automatic push_bytes(input int n, input bit whole);
        for (int i = 0; i < n; i++) begin
            q.push_back(seq);
            expq.push_back(seq);
            seq = seq * 8'd5 + 8'd3;
        end
        if (whole) pending++;
    endtask

    // One clock: drive at the falling edge, observe once settled
    task automatic tick(input bit rdy);
        @(negedge clk);
        if (pop_pend) begin
            void'(q.pop_front());
            pop_pend = 0;
        end
        fifo_data  = (q.size() != 0) ? q[0] : 8'h00;
        fifo_cells = 8'(pending);
        tx_ready   = rdy;
        lfsr       = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cyc++;
        #1;
        if (!rst_n) return;
        if (fifo_rd) begin
            reads++;
            if (q.size() == 0) chk(0, "R3 read from empty FIFO", 0, 1);
            if (rd_pos == 0) pending--;
            pop_pend = 1;
            rd_pos = (rd_pos + 1) % CL;
        end
        if (tx_valid && tx_ready) begin
            if (expq.size() == 0) begin
                chk(0, "R8 unexpected octet", tx_octet, -1);
            end else begin
                logic [7:0] e;
                e = expq.pop_front();
                chk(tx_octet == e, "R8 octet order", tx_octet, e);
            end
            chk(tx_soc == (out_pos == 0), "R1 soc position", tx_soc, out_pos == 0);
            if (tx_soc) socs++;
            accepted++;
            if (first_acc < 0) first_acc = cyc;
            last_acc = cyc;
            out_pos = (out_pos + 1) % CL;
        end
    endtask

    task automatic clear_stats();
        accepted = 0; socs = 0; reads = 0; first_acc = -1; last_acc = -1;
    endtask

    task automatic drain(input int total, input int mode);
        for (int i = 0; i < 4000 && accepted < total; i++) tick(ready_of(mode));
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Reset state (R9, R4)
        rst_n = 1'b0;
        tick(1'b1); tick(1'b1);
        rst_n = 1'b1;
        tick(1'b1);
        chk(tx_valid == 0, "R9 valid after reset", tx_valid, 0);
        chk(tx_soc == 0, "R9 soc after reset", tx_soc, 0);
        chk(tx_nocell == 1, "R4 nocell when FIFO empty", tx_nocell, 1);
        chk(fifo_rd == 0, "R3 no read when FIFO empty", fifo_rd, 0);

        // Table-driven scenarios (R1, R2, R5, R6)
        foreach (VEC[k]) begin
            int ncell;
            int mode;
            ncell = int'(VEC[k][11:4]);
            mode  = int'(VEC[k][3:0]);
            clear_stats();
            for (int c = 0; c < ncell; c++) push_bytes(CL, 1'b1);
            drain(ncell * CL, mode);
            chk(accepted == ncell * CL, "R6 all octets of every cell", accepted, ncell * CL);
            chk(socs == ncell, "R2 one soc per cell", socs, ncell);
            if (mode == 0)
                chk(last_acc - first_acc + 1 == ncell * CL, "R5 no gap in stream",
                    last_acc - first_acc + 1, ncell * CL);
            for (int i = 0; i < 6; i++) tick(1'b1);
            chk(tx_valid == 0, "R4 idle after drain", tx_valid, 0);
            chk(tx_nocell == 1, "R4 nocell after drain", tx_nocell, 1);
        end

        // Partial cell must not be read (R3)
        clear_stats();
        push_bytes(30, 1'b0);
        for (int i = 0; i < 40; i++) tick(1'b1);
        chk(reads == 0, "R3 partial cell not read", reads, 0);
        chk(tx_valid == 0, "R3 no output from partial cell", tx_valid, 0);
        chk(tx_nocell == 1, "R4 nocell with partial cell", tx_nocell, 1);
        push_bytes(CL - 30, 1'b1);
        drain(CL, 0);
        chk(accepted == CL && socs == 1, "R3 completed cell delivered", accepted, CL);

        // Back-pressure hold (R7)
        clear_stats();
        push_bytes(CL, 1'b1);
        for (int i = 0; i < 20 && !tx_valid; i++) tick(1'b1);
        for (int i = 0; i < 3; i++) tick(1'b1);
        begin
            logic [7:0] held;
            logic hs;
            tick(1'b0);
            held = tx_octet; hs = tx_soc;
            for (int i = 0; i < 5; i++) begin
                tick(1'b0);
                chk(tx_valid && tx_octet == held && tx_soc == hs, "R7 hold under stall",
                    tx_octet, held);
            end
        end
        drain(CL, 0);
        chk(accepted == CL, "R7 cell intact after stall", accepted, CL);
        for (int i = 0; i < 4; i++) tick(1'b1);

        // Reset in the middle of a cell (R9)
        clear_stats();
        push_bytes(CL, 1'b1);
        drain(10, 0);
        rst_n = 1'b0;
        tick(1'b1);
        rst_n = 1'b1;
        q.delete(); expq.delete();
        pending = 0; rd_pos = 0; out_pos = 0; pop_pend = 0;
        tick(1'b1);
        chk(tx_valid == 0, "R9 output empty after reset", tx_valid, 0);
        clear_stats();
        push_bytes(CL, 1'b1);
        drain(CL, 2);
        chk(accepted == CL && socs == 1, "R9 fresh cell after reset", socs, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule